// File: doc/BRIEF.md
# Analog Boundary Module Control Cell

This block is the digital control cell that sits next to one analog function pin in a mixed-signal boundary-scan chain. It holds a four-bit scan word that moves from `scan_in` toward `scan_out` while the shift strobe is high. On the capture strobe it samples the comparator that digitizes the pin against a threshold. On the update strobe it turns the scanned word into enables for the pin's analog switches: isolate the core, drive the high or the low reference, connect the ground return, or attach the pin to internal analog bus 1 (to source current) or bus 2 (to sense voltage).

The instruction decoder outside the cell supplies two decoded mode inputs. `drive_mode` is the digital-compatible mode (EXTEST-like), in which the data bit drives exactly one reference level. `probe_mode` is the analog measurement mode, in which the two-bit select code picks ground, bus 1 or bus 2. With neither input high the cell behaves like a SAMPLE/PRELOAD boundary cell: capture and shift still work and the word is still latched, but every switch stays open. A small phase machine runs the cell. Its states are PH_IDLE, PH_CAPTURE, PH_SHIFT and PH_UPDATE. Every cycle the machine takes the transition that the strobes select. The capture strobe leads to PH_CAPTURE, the shift strobe to PH_SHIFT and the update strobe to PH_UPDATE, in that priority order. With no strobe high, the machine returns to PH_IDLE. The datapath acts on the phase being entered.

The switch enables are registered. They change only on an update, so shifting never disturbs the analog pin. An asynchronous reset, driven from the TAP's Test-Logic-Reset state, opens every switch at once.

Top module: `abm_ctl_cell`

## Requirements
- R1: On a capture strobe the scan word is loaded with the comparator level in bit 0 (data) and with the latched update word in bits 3:1.
- R2: On a shift strobe the word moves one place toward `scan_out`, which shows bit 0, while `scan_in` enters bit 3. After four shifts, the first bit shifted in sits in bit 0 (data), then bit 1 (core disconnect), then bits 3:2 (select code).
- R3: The switch enables change only on an update strobe. A capture, a shift, or a change of mode input leaves them unchanged.
- R4: An active-low asynchronous reset clears the scan word, the latched word and every enable. The core stays connected and no test switch is closed.
- R5: In drive mode, an update asserts exactly one reference enable: high when data is 1 and low when data is 0.
- R6: The high and low reference enables are never high together. While a reference level is driven, the ground and both bus enables are forced off whatever the select code.
- R7: In probe mode, select code 00 closes nothing, 01 closes the ground return, 10 closes bus 1 and 11 closes bus 2. No reference enable is asserted.
- R8: In either test mode the core-disconnect enable follows bit 1 regardless of the other bits. With no mode input high, an update opens every switch.
- R9: With both mode inputs high, drive mode takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset from Test-Logic-Reset |
| capture_dr | input | 1 | Capture strobe, one cycle |
| shift_dr | input | 1 | Shift strobe, one cycle per bit |
| update_dr | input | 1 | Update strobe, one cycle |
| scan_in | input | 1 | Serial data from the previous cell |
| comp_in | input | 1 | Comparator output: pin level against threshold |
| drive_mode | input | 1 | Decoded digital-compatible (drive) mode |
| probe_mode | input | 1 | Decoded analog probe mode |
| scan_out | output | 1 | Serial data toward the next cell |
| en_core_off | output | 1 | Disconnect the core from the pin |
| en_ref_hi | output | 1 | Connect the pin to the high reference |
| en_ref_lo | output | 1 | Connect the pin to the low reference |
| en_gnd | output | 1 | Connect the pin to the ground return |
| en_bus1 | output | 1 | Connect the pin to analog bus 1 |
| en_bus2 | output | 1 | Connect the pin to analog bus 2 |

## Verification
The assertions assume that the TAP raises at most one strobe in a cycle, as a real controller does. They also assume that the mode inputs are stable while an update is performed. The bench drives each strobe alone for one cycle, and it changes the mode inputs only in cycles without an update. Within those limits the bench sweeps every four-bit word under all four mode combinations. It reads each captured word back through `scan_out`.

// File: rtl/abm_ctl_pkg.sv
package abm_ctl_pkg;
    localparam int SEL_W    = 2;
    localparam int CELL_W   = 2 + SEL_W;
    localparam int DATA_POS = 0;
    localparam int DISC_POS = 1;
    localparam int SEL_LSB  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 2'b00,
        SEL_GND  = 2'b01,
        SEL_BUS1 = 2'b10,
        SEL_BUS2 = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAPTURE,
        PH_SHIFT,
        PH_UPDATE
    } phase_e;

    typedef enum logic [1:0] {
        MD_OFF,
        MD_DRIVE,
        MD_PROBE
    } mode_e;

    typedef struct packed {
        logic core_off;
        logic ref_hi;
        logic ref_lo;
        logic gnd;
        logic bus1;
        logic bus2;
    } sw_en_t;
endpackage

// File: rtl/abm_scan_stage.sv
module abm_scan_stage
    import abm_ctl_pkg::*;
#(
    parameter int W = CELL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_fire,
    input  logic         shift_fire,
    input  logic         scan_in,
    input  logic         comp_in,
    input  logic [W-1:0] hold_bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap_fire) begin
            q <= {hold_bits[W-1:1], comp_in};
        end else if (shift_fire) begin
            q <= {scan_in, q[W-1:1]};
        end
    end

    // R1: comparator level lands in the data bit on capture
    a_r1_capture_comp: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> q[DATA_POS] == $past(comp_in));

    // R2: serial input enters the far end on shift
    a_r2_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_fire && !cap_fire) |=> q[W-1] == $past(scan_in));

    // R2: the rest of the word moves one place toward the output
    a_r2_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_fire && !cap_fire) |=> q[W-2:0] == $past(q[W-1:1]));
endmodule

// File: rtl/abm_switch_decode.sv
module abm_switch_decode
    import abm_ctl_pkg::*;
#(
    parameter int W = CELL_W
) (
    input  mode_e        mode,
    input  logic [W-1:0] bits,
    output sw_en_t       en
);
    sel_e sel;
    assign sel = sel_e'(bits[SEL_LSB +: SEL_W]);

    always_comb begin
        en = '0;
        unique case (mode)
            MD_DRIVE: begin
                en.core_off = bits[DISC_POS];
                en.ref_hi   = bits[DATA_POS];
                en.ref_lo   = !bits[DATA_POS];
            end
            MD_PROBE: begin
                en.core_off = bits[DISC_POS];
                unique case (sel)
                    SEL_GND:  en.gnd  = 1'b1;
                    SEL_BUS1: en.bus1 = 1'b1;
                    SEL_BUS2: en.bus2 = 1'b1;
                    default:  en.gnd  = 1'b0;
                endcase
            end
            default: en = '0;
        endcase
    end
endmodule

// File: rtl/abm_update_stage.sv
module abm_update_stage
    import abm_ctl_pkg::*;
#(
    parameter int W = CELL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_fire,
    input  logic [W-1:0] nx_bits,
    input  sw_en_t       nx_en,
    output logic [W-1:0] hold_bits,
    output sw_en_t       en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_bits <= '0;
            en        <= '0;
        end else if (upd_fire) begin
            hold_bits <= nx_bits;
            en        <= nx_en;
        end
    end

    // R3: enables hold between updates
    a_r3_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_fire |=> $stable(en));

    // R6: references mutually exclusive
    a_r6_ref_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(en.ref_hi && en.ref_lo));

    // R6: no bus or ground while a reference is driven
    a_r6_no_bus_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (en.ref_hi || en.ref_lo) |-> !(en.gnd || en.bus1 || en.bus2));

    // R7: at most one of ground, bus 1, bus 2
    a_r7_single_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en.gnd, en.bus1, en.bus2}));
endmodule

// File: rtl/abm_ctl_cell.sv
module abm_ctl_cell
    import abm_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic scan_in,
    input  logic comp_in,
    input  logic drive_mode,
    input  logic probe_mode,
    output logic scan_out,
    output logic en_core_off,
    output logic en_ref_hi,
    output logic en_ref_lo,
    output logic en_gnd,
    output logic en_bus1,
    output logic en_bus2
);
    phase_e              phase_q;
    phase_e              phase_nx;
    mode_e               mode;
    logic                cap_fire;
    logic                shift_fire;
    logic                upd_fire;
    logic [CELL_W-1:0]   scan_q;
    logic [CELL_W-1:0]   hold_bits;
    sw_en_t              nx_en;
    sw_en_t              en_q;

    // Phase transitions chosen by the strobes, capture first
    always_comb begin
        if (capture_dr)     phase_nx = PH_CAPTURE;
        else if (shift_dr)  phase_nx = PH_SHIFT;
        else if (update_dr) phase_nx = PH_UPDATE;
        else                phase_nx = PH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_nx;
    end

    // Actions for the phase being entered
    always_comb begin
        cap_fire   = 1'b0;
        shift_fire = 1'b0;
        upd_fire   = 1'b0;
        unique case (phase_nx)
            PH_CAPTURE: cap_fire   = 1'b1;
            PH_SHIFT:   shift_fire = 1'b1;
            PH_UPDATE:  upd_fire   = 1'b1;
            default:    cap_fire   = 1'b0;
        endcase
    end

    // Drive mode wins when both decoded inputs are high
    always_comb begin
        if (drive_mode)      mode = MD_DRIVE;
        else if (probe_mode) mode = MD_PROBE;
        else                 mode = MD_OFF;
    end

    abm_scan_stage #(.W(CELL_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_fire   (cap_fire),
        .shift_fire (shift_fire),
        .scan_in    (scan_in),
        .comp_in    (comp_in),
        .hold_bits  (hold_bits),
        .q          (scan_q)
    );

    abm_switch_decode #(.W(CELL_W)) u_dec (
        .mode (mode),
        .bits (scan_q),
        .en   (nx_en)
    );

    abm_update_stage #(.W(CELL_W)) u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_fire  (upd_fire),
        .nx_bits   (scan_q),
        .nx_en     (nx_en),
        .hold_bits (hold_bits),
        .en        (en_q)
    );

    assign scan_out    = scan_q[DATA_POS];
    assign en_core_off = en_q.core_off;
    assign en_ref_hi   = en_q.ref_hi;
    assign en_ref_lo   = en_q.ref_lo;
    assign en_gnd      = en_q.gnd;
    assign en_bus1     = en_q.bus1;
    assign en_bus2     = en_q.bus2;

    // R5: a drive-mode update closes exactly one reference switch
    a_r5_one_ref_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && drive_mode) |=> $countones({en_ref_hi, en_ref_lo}) == 1);

    // R8: with no mode selected an update opens all switches
    a_r8_off_mode_open: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_fire && !drive_mode && !probe_mode) |=>
            !(en_core_off || en_ref_hi || en_ref_lo || en_gnd || en_bus1 || en_bus2));

    // R3: the phase register follows the update strobe
    a_r3_phase_track: assert property (@(posedge clk) disable iff (!rst_n)
        (update_dr && !capture_dr && !shift_dr) |=> phase_q == PH_UPDATE);
endmodule

// File: tb/abm_ctl_cell_test.sv
module abm_ctl_cell_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic scan_in = 1'b0, comp_in = 1'b0;
    logic drive_mode = 1'b0, probe_mode = 1'b0;
    logic scan_out;
    logic en_core_off, en_ref_hi, en_ref_lo, en_gnd, en_bus1, en_bus2;

    int vectors = 0;
    int errors = 0;

    always #4 clk = ~clk;

    abm_ctl_cell uut (
        .clk(clk), .rst_n(rst_n),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .scan_in(scan_in), .comp_in(comp_in),
        .drive_mode(drive_mode), .probe_mode(probe_mode),
        .scan_out(scan_out),
        .en_core_off(en_core_off), .en_ref_hi(en_ref_hi), .en_ref_lo(en_ref_lo),
        .en_gnd(en_gnd), .en_bus1(en_bus1), .en_bus2(en_bus2)
    );

    function automatic logic [5:0] all_en();
        return {en_core_off, en_ref_hi, en_ref_lo, en_gnd, en_bus1, en_bus2};
    endfunction

    // bit order {core_off, hi, lo, gnd, bus1, bus2}; md[0]=drive, md[1]=probe
    function automatic logic [5:0] expect_en(input logic [1:0] md, input logic [3:0] w);
        if (md[0])      return {w[1], w[0], ~w[0], 3'b000};
        else if (md[1]) return {w[1], 2'b00, w[3:2] == 2'd1, w[3:2] == 2'd2, w[3:2] == 2'd3};
        else            return 6'b0;
    endfunction

    task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_word(input logic [3:0] w, output logic [3:0] got);
        for (int i = 0; i < 4; i++) begin
            got[i]   = scan_out;
            scan_in  = w[i];
            shift_dr = 1'b1;
            step();
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
    endtask

    task automatic do_capture(input logic c);
        comp_in    = c;
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [5:0] prev;
        logic [3:0] rd;
        string tag;
        @(negedge clk);
        // R4: state while reset is held
        check("R4 reset enables", all_en(), 6'b0);
        check("R4 reset scan_out", {5'b0, scan_out}, 6'b0);
        step();
        rst_n = 1'b1;
        step();
        prev = 6'b0;

        for (int md = 0; md < 4; md++) begin
            for (int w = 0; w < 16; w++) begin
                drive_mode = md[0];
                probe_mode = md[1];
                shift_word(w[3:0], rd);
                // R3: shifting and mode change leave the enables alone
                check("R3 shift holds", all_en(), prev);
                do_update();
                case (md)
                    0: tag = "R8 off mode";
                    1: tag = "R5 drive mode";
                    2: tag = "R7 probe mode";
                    default: tag = "R9 both modes";
                endcase
                check(tag, all_en(), expect_en(md[1:0], w[3:0]));
                // R6: never both references, no path while driving
                check("R6 exclusivity",
                      {4'b0, en_ref_hi && en_ref_lo,
                       (en_ref_hi || en_ref_lo) && (en_gnd || en_bus1 || en_bus2)}, 6'b0);
                prev = expect_en(md[1:0], w[3:0]);
                do_capture(~w[0]);
                // R3: capture does not move the enables
                check("R3 capture holds", all_en(), prev);
                shift_word(4'b0000, rd);
                // R1 and R2: read back {latched[3:1], comparator}, bit 0 first
                check("R1 R2 capture readback", {2'b0, rd}, {2'b0, w[3:1], ~w[0]});
            end
        end

        // R8: core disconnect independent of the other bits in probe mode
        drive_mode = 1'b0;
        probe_mode = 1'b1;
        shift_word(4'b0010, rd);
        do_update();
        check("R8 disconnect alone", all_en(), 6'b100000);

        // R4: asynchronous reset in mid-cycle
        drive_mode = 1'b1;
        shift_word(4'b1111, rd);
        do_update();
        check("R4 preset", all_en(), 6'b110000);
        #2 rst_n = 1'b0;
        #1;
        check("R4 async clear", all_en(), 6'b0);
        check("R4 async scan clear", {5'b0, scan_out}, 6'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        do_capture(1'b0);
        shift_word(4'b0000, rd);
        check("R4 latched word cleared", {2'b0, rd}, 6'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule